// File: doc/BRIEF.md
# DRAM Open-Bank Tracker with Least-Recently-Used Replacement

This block sits between a command source and the DRAM command sequencer of a DDR2-style memory controller. It records which banks currently have a row open, at most four at a time. For every incoming access it decides whether the target bank must first be closed with a precharge, then opened with an activate, or whether the access can go straight on. Precharge and activate requests leave through their own valid/ready pairs. Once they have been acknowledged, the command is released downstream with a one-cycle pulse. That pulse says whether an activate was issued for this command.

Each of the four entries holds a bank address, a row address and an open bit. When a new bank is needed, an empty entry is used if one exists. Otherwise the entry used least recently is closed and reused. The upstream source supplies a conflict flag. The flag is raised when an access differs in bank or row from the access before it, so an unflagged access is taken to hit the bank and row used last.

A refresh closes every bank. When the refresh ends, the tracker on its own reopens the bank and row of the last access. This keeps the upstream flag consistent with what is really open in the DRAM. The refresh scheduler, DRAM timing and column commands are handled outside this block.

Top module: `bankTracker`

## Requirements
- R1: After reset, cmdReady is 1, preValid, actValid and relValid are 0, and no entry is open, so the first command produces an activate.
- R2: A command to a bank held by no open entry, while at least one entry is closed, produces one activate of its bank and row with no precharge, and fills the closed entry with the lowest index.
- R3: A command to a bank held by no open entry while all four entries are open produces a precharge of the least recently used entry's bank, then an activate of the new bank and row into that entry.
- R4: A flagged command (cmdConflict=1) whose bank is open with a different row produces a precharge of that bank, then an activate of the new row in the same entry.
- R5: A flagged command whose bank and row both match an open entry is a false conflict: no precharge and no activate are issued, and relActivated is 0 at release.
- R6: An unflagged command (cmdConflict=0), while the entry used by the previous command is open, is treated as a hit on that entry: no precharge and no activate are issued.
- R7: Each hit and each activation makes its entry the most recently used one, and eviction always picks the least recently used entry.
- R8: A refStart pulse taken while cmdReady is 1 closes all entries, and cmdReady stays 0 until refDone has arrived and any reopen activate has been acknowledged.
- R9: On refDone, if any command has been accepted since reset, an activate of the last accessed bank and row is issued with no incoming command, and that entry is open afterwards. No release pulse accompanies it. If no command has been accepted, nothing is issued.
- R10: A precharge for a command is acknowledged before its activate. preValid and actValid are never both 1, and each valid with its fields holds steady until its ready is seen.
- R11: Only one command is in flight: cmdReady is 0 from the cycle after acceptance until the release. relValid lasts one cycle, and relActivated is 1 only when an activate was issued for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command accepted on the edge where cmdValid is also 1 |
| cmdBank | input | BANK_W | Bank address of the command |
| cmdRow | input | ROW_W | Row address of the command |
| cmdConflict | input | 1 | Upstream flag: bank or row differs from the previous command |
| refStart | input | 1 | Pulse: an auto refresh begins (only taken when cmdReady is 1) |
| refDone | input | 1 | Pulse: the auto refresh has completed |
| preValid | output | 1 | Precharge request |
| preReady | input | 1 | Precharge accepted |
| preBank | output | BANK_W | Bank to precharge |
| actValid | output | 1 | Activate request |
| actReady | input | 1 | Activate accepted |
| actBank | output | BANK_W | Bank to activate |
| actRow | output | ROW_W | Row to activate |
| relValid | output | 1 | One-cycle release of the current command |
| relActivated | output | 1 | An activate was issued for the released command |

## Verification
A closed entry that is wrongly left marked open shows up at the next command to that bank. That command is released with no activate. An open entry wrongly cleared shows up as an extra activate, without a precharge, on the next command that should have hit. A corrupted recency order stays hidden until all four entries are full and a new bank arrives. The preBank of that eviction then names the wrong bank, which can be several commands after the fault. A wrong last-access record shows up at the first refDone as an activate of the wrong bank or row, or as a reopen that never comes.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    DEC_HIT    = 2'd0,
    DEC_ACT    = 2'd1,
    DEC_PREACT = 2'd2
  } decKind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PRE    = 3'd1,
    S_ACT    = 3'd2,
    S_REL    = 3'd3,
    S_REF    = 3'd4,
    S_REOPEN = 3'd5
  } ctlState_e;

  // strobes from the control FSM to the entry datapath
  typedef struct packed {
    logic latchCmd;
    logic latchReopen;
    logic commitAct;
    logic touchHit;
    logic clearAll;
  } dpCtl_t;

endpackage

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int NUM_ENT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic              cmdConflict,
  output decKind_e          decKind,
  output logic              canReopen,
  output logic [BANK_W-1:0] preBank,
  output logic [BANK_W-1:0] actBank,
  output logic [ROW_W-1:0]  actRow
);

  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int LAST  = NUM_ENT - 1;

  logic [BANK_W-1:0] entBank [NUM_ENT];
  logic [ROW_W-1:0]  entRow  [NUM_ENT];
  logic [NUM_ENT-1:0] entOpen;
  logic [IDX_W-1:0]  order   [NUM_ENT];   // order[0] most recent, order[LAST] least
  logic [IDX_W-1:0]  newOrder[NUM_ENT];

  logic [IDX_W-1:0]  lastIdx, tgtIdx;
  logic              lastKnown;
  logic [BANK_W-1:0] pBankQ, aBankQ;
  logic [ROW_W-1:0]  aRowQ;

  logic [NUM_ENT-1:0] bankHit, rowHit;
  logic [IDX_W-1:0]  freeIdx, hitIdx, bhIdx, decIdx, touchIdx;
  logic [BANK_W-1:0] decPreBank;
  logic              fastHit;

  // per-entry compare
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign bankHit[g] = entOpen[g] && (entBank[g] == cmdBank);
    assign rowHit[g]  = bankHit[g] && (entRow[g] == cmdRow);
  end

  always_comb begin
    freeIdx = '0;
    hitIdx  = '0;
    bhIdx   = '0;
    for (int i = LAST; i >= 0; i--) begin
      if (!entOpen[i]) freeIdx = IDX_W'(i);
      if (rowHit[i])   hitIdx  = IDX_W'(i);
      if (bankHit[i])  bhIdx   = IDX_W'(i);
    end
  end

  assign fastHit = !cmdConflict && lastKnown && entOpen[lastIdx];

  always_comb begin
    decKind    = DEC_ACT;
    decIdx     = freeIdx;
    decPreBank = cmdBank;
    if (fastHit) begin
      decKind = DEC_HIT;
      decIdx  = lastIdx;
    end else if (|rowHit) begin
      decKind = DEC_HIT;
      decIdx  = hitIdx;
    end else if (|bankHit) begin
      decKind = DEC_PREACT;
      decIdx  = bhIdx;
    end else if (!(&entOpen)) begin
      decKind = DEC_ACT;
      decIdx  = freeIdx;
    end else begin
      decKind    = DEC_PREACT;
      decIdx     = order[LAST];
      decPreBank = entBank[order[LAST]];
    end
  end

  // move-to-front of the touched entry
  assign touchIdx = ctl.touchHit ? decIdx : tgtIdx;

  always_comb begin
    int posI;
    posI = LAST;
    for (int i = 0; i < NUM_ENT; i++)
      if (order[i] == touchIdx) posI = i;
    newOrder[0] = touchIdx;
    for (int i = 1; i < NUM_ENT; i++)
      newOrder[i] = (i <= posI) ? order[i-1] : order[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entOpen   <= '0;
      lastIdx   <= '0;
      tgtIdx    <= '0;
      lastKnown <= 1'b0;
      pBankQ    <= '0;
      aBankQ    <= '0;
      aRowQ     <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        order[i]   <= IDX_W'(i);
        entBank[i] <= '0;
        entRow[i]  <= '0;
      end
    end else begin
      if (ctl.clearAll) entOpen <= '0;
      if (ctl.latchCmd) begin
        tgtIdx <= decIdx;
        pBankQ <= decPreBank;
        aBankQ <= cmdBank;
        aRowQ  <= cmdRow;
      end
      if (ctl.latchReopen) begin
        tgtIdx <= lastIdx;
        aBankQ <= entBank[lastIdx];
        aRowQ  <= entRow[lastIdx];
      end
      if (ctl.commitAct) begin
        entBank[tgtIdx] <= aBankQ;
        entRow[tgtIdx]  <= aRowQ;
        entOpen[tgtIdx] <= 1'b1;
        lastIdx         <= tgtIdx;
        lastKnown       <= 1'b1;
      end
      if (ctl.touchHit) lastIdx <= decIdx;
      if (ctl.touchHit || ctl.commitAct) order <= newOrder;
    end
  end

  assign canReopen = lastKnown;
  assign preBank   = pBankQ;
  assign actBank   = aBankQ;
  assign actRow    = aRowQ;

endmodule

// File: rtl/bt_control.sv
module bt_control
  import bt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     refStart,
  input  logic     refDone,
  input  logic     preReady,
  input  logic     actReady,
  input  decKind_e decKind,
  input  logic     canReopen,
  output logic     cmdReady,
  output logic     preValid,
  output logic     actValid,
  output logic     relValid,
  output logic     relActivated,
  output dpCtl_t   ctl
);

  ctlState_e state, stateNxt;
  logic      actDoneQ, actDoneNxt;

  assign cmdReady = (state == S_IDLE) && !refStart;

  always_comb begin
    stateNxt   = state;
    actDoneNxt = actDoneQ;
    ctl        = '0;
    unique case (state)
      S_IDLE: begin
        if (refStart) begin
          ctl.clearAll = 1'b1;
          stateNxt     = S_REF;
        end else if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          actDoneNxt   = 1'b0;
          unique case (decKind)
            DEC_HIT: begin
              ctl.touchHit = 1'b1;
              stateNxt     = S_REL;
            end
            DEC_ACT:    stateNxt = S_ACT;
            default:    stateNxt = S_PRE;
          endcase
        end
      end
      S_PRE: if (preReady) stateNxt = S_ACT;
      S_ACT: if (actReady) begin
        ctl.commitAct = 1'b1;
        actDoneNxt    = 1'b1;
        stateNxt      = S_REL;
      end
      S_REL: stateNxt = S_IDLE;
      S_REF: if (refDone) begin
        if (canReopen) begin
          ctl.latchReopen = 1'b1;
          stateNxt        = S_REOPEN;
        end else begin
          stateNxt = S_IDLE;
        end
      end
      S_REOPEN: if (actReady) begin
        ctl.commitAct = 1'b1;
        stateNxt      = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      actDoneQ <= 1'b0;
    end else begin
      state    <= stateNxt;
      actDoneQ <= actDoneNxt;
    end
  end

  assign preValid     = (state == S_PRE);
  assign actValid     = (state == S_ACT) || (state == S_REOPEN);
  assign relValid     = (state == S_REL);
  assign relActivated = relValid && actDoneQ;

endmodule

// File: rtl/bankTracker.sv
module bankTracker
  import bt_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int NUM_ENT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic              cmdConflict,
  input  logic              refStart,
  input  logic              refDone,
  output logic              preValid,
  input  logic              preReady,
  output logic [BANK_W-1:0] preBank,
  output logic              actValid,
  input  logic              actReady,
  output logic [BANK_W-1:0] actBank,
  output logic [ROW_W-1:0]  actRow,
  output logic              relValid,
  output logic              relActivated
);

  dpCtl_t   ctl;
  decKind_e decKind;
  logic     canReopen;

  bt_control u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .refStart(refStart),
    .refDone(refDone), .preReady(preReady), .actReady(actReady),
    .decKind(decKind), .canReopen(canReopen), .cmdReady(cmdReady),
    .preValid(preValid), .actValid(actValid), .relValid(relValid),
    .relActivated(relActivated), .ctl(ctl)
  );

  bt_datapath #(.BANK_W(BANK_W), .ROW_W(ROW_W), .NUM_ENT(NUM_ENT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdConflict(cmdConflict), .decKind(decKind), .canReopen(canReopen),
    .preBank(preBank), .actBank(actBank), .actRow(actRow)
  );

endmodule

// File: rtl/bankTracker_chk.sv
module bankTracker_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              preValid,
  input logic              preReady,
  input logic [BANK_W-1:0] preBank,
  input logic              actValid,
  input logic              actReady,
  input logic [BANK_W-1:0] actBank,
  input logic [ROW_W-1:0]  actRow,
  input logic              relValid
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(preValid && actValid));

  p_pre_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    preValid && !preReady |=> preValid && $stable(preBank));

  p_act_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    actValid && !actReady |=> actValid && $stable(actBank) && $stable(actRow));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);

  p_rel_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    relValid |=> !relValid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !preValid && !actValid && !relValid);

endmodule

bind bankTracker bankTracker_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .preValid(preValid), .preReady(preReady), .preBank(preBank),
  .actValid(actValid), .actReady(actReady), .actBank(actBank),
  .actRow(actRow), .relValid(relValid)
);

// File: tb/tb_bankTracker.sv
`timescale 1ns/1ps
module tb_bankTracker;

  localparam int BANK_W = 3;
  localparam int ROW_W  = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdConflict = 1'b0, refStart = 1'b0, refDone = 1'b0;
  logic preReady = 1'b0, actReady = 1'b0;
  logic [BANK_W-1:0] cmdBank = '0;
  logic [ROW_W-1:0]  cmdRow = '0;
  logic cmdReady, preValid, actValid, relValid, relActivated;
  logic [BANK_W-1:0] preBank, actBank;
  logic [ROW_W-1:0]  actRow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bankTracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdConflict(cmdConflict),
    .refStart(refStart), .refDone(refDone), .preValid(preValid),
    .preReady(preReady), .preBank(preBank), .actValid(actValid),
    .actReady(actReady), .actBank(actBank), .actRow(actRow),
    .relValid(relValid), .relActivated(relActivated)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // results of the last serviced window
  int gPre, gAct, gRel, gRelAct, gPreBank, gActBank, gActRow, gOrderBad;

  task automatic service(input int stall, input bit untilIdle);
    int waitP = 0, waitA = 0;
    bit done = 1'b0;
    gPre = 0; gAct = 0; gRel = 0; gRelAct = 0; gOrderBad = 0;
    gPreBank = -1; gActBank = -1; gActRow = -1;
    for (int c = 0; c < 60 && !done; c++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      if (preValid) begin
        if (gAct > 0) gOrderBad = 1;
        if (waitP >= stall) begin
          preReady = 1'b1; gPre++; gPreBank = int'(preBank); waitP = 0;
        end else begin
          preReady = 1'b0; waitP++;
        end
      end else preReady = 1'b0;
      if (actValid) begin
        if (waitA >= stall) begin
          actReady = 1'b1; gAct++; gActBank = int'(actBank);
          gActRow = int'(actRow); waitA = 0;
        end else begin
          actReady = 1'b0; waitA++;
        end
      end else actReady = 1'b0;
      if (relValid) begin
        gRel++; gRelAct = int'(relActivated);
      end
      done = untilIdle ? (cmdReady && !preValid && !actValid) : relValid;
    end
  endtask

  task automatic runCmd(input int bank, input int row, input bit conf,
                        input int expPre, input int expPreBank,
                        input int expAct, input string req, input int stall);
    @(negedge clk);
    cmdBank = BANK_W'(bank); cmdRow = ROW_W'(row); cmdConflict = conf;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!cmdReady, "R11", "cmdReady after accept", int'(cmdReady), 0);
    if (relValid) begin
      gPre = 0; gAct = 0; gRel = 1; gRelAct = int'(relActivated); gOrderBad = 0;
      @(negedge clk);
    end else begin
      service(stall, 1'b0);
    end
    chk(gRel == 1, req, "release seen", gRel, 1);
    chk(gPre == expPre, req, "precharge count", gPre, expPre);
    if (expPre > 0)
      chk(gPreBank == expPreBank, req, "precharge bank", gPreBank, expPreBank);
    chk(gAct == expAct, req, "activate count", gAct, expAct);
    if (expAct > 0) begin
      chk(gActBank == bank, req, "activate bank", gActBank, bank);
      chk(gActRow == row, req, "activate row", gActRow, row);
    end
    chk(gOrderBad == 0, "R10", "precharge before activate", gOrderBad, 0);
    chk(gRelAct == expAct, "R11", "relActivated", gRelAct, expAct);
  endtask

  task automatic doRefresh(input int expAct, input int bank, input int row);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    refStart = 1'b1;
    @(negedge clk);
    refStart = 1'b0;
    chk(!cmdReady, "R8", "cmdReady during refresh", int'(cmdReady), 0);
    repeat (3) @(negedge clk);
    chk(!cmdReady && !actValid, "R8", "blocked until refDone",
        int'(cmdReady | actValid), 0);
    refDone = 1'b1;
    @(negedge clk);
    refDone = 1'b0;
    service(1, 1'b1);
    chk(gAct == expAct, "R9", "reopen activate count", gAct, expAct);
    if (expAct > 0) begin
      chk(gActBank == bank, "R9", "reopen bank", gActBank, bank);
      chk(gActRow == row, "R9", "reopen row", gActRow, row);
    end
    chk(gRel == 0, "R9", "no release on reopen", gRel, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk(cmdReady == 1'b1, "R1", "cmdReady after reset", int'(cmdReady), 1);
    chk(!preValid && !actValid && !relValid, "R1", "idle outputs",
        int'({preValid, actValid, relValid}), 0);
  endtask

  task automatic testFill();
    runCmd(1, 10, 1'b1, 0, 0, 1, "R1", 0);   // first command must activate
    runCmd(1, 10, 1'b1, 0, 0, 0, "R5", 0);   // false conflict
    runCmd(2, 20, 1'b1, 0, 0, 1, "R2", 0);
    runCmd(3, 30, 1'b1, 0, 0, 1, "R2", 1);
    runCmd(4, 40, 1'b1, 0, 0, 1, "R2", 0);
  endtask

  task automatic testEvict();
    runCmd(2, 20, 1'b1, 0, 0, 0, "R7", 0);   // hit refreshes bank 2
    runCmd(5, 50, 1'b1, 1, 1, 1, "R3", 2);   // evicts bank 1
    runCmd(2, 21, 1'b1, 1, 2, 1, "R4", 1);   // row miss on bank 2
    runCmd(2, 21, 1'b0, 0, 0, 0, "R6", 0);   // unflagged follow-on
    runCmd(6, 60, 1'b1, 1, 3, 1, "R7", 0);   // bank 3 is now oldest
  endtask

  task automatic testRefresh();
    doRefresh(1, 6, 60);
    runCmd(6, 60, 1'b1, 0, 0, 0, "R9", 0);   // reopened entry hits
    runCmd(5, 50, 1'b1, 0, 0, 1, "R8", 0);   // closed by refresh, free entry
    doRefresh(1, 5, 50);
    runCmd(5, 50, 1'b0, 0, 0, 0, "R6", 0);
    doReset();
    doRefresh(0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testFill();
    testEvict();
    testRefresh();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule